// File: doc/BRIEF.md
# Low-Power Sleep Sequencer for a Synchronous Memory

This block sits beside the access path of a synchronous memory and handles a sleep request pin that may change at any time with no relation to the clock. It brings the request into the clock domain through a flop synchroniser. It then steps through a timed entry phase into a low-power phase. When the request is withdrawn, it steps through a timed recovery phase before it allows accesses again.

Accesses are granted only while the memory is fully awake. If the device is still selected, or an address strobe is still active, at the moment entry starts, the block raises a sticky entry error. Any access still in flight at that moment is reported as invalid through a one-cycle pulse. Any select or strobe seen during the recovery window is refused and recorded in a second sticky flag. An asynchronous reset clears both sticky flags. The block holds no array, so retention of the stored contents is left to the array itself.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `sleep_o` is 0, `access_ok_o` is 1, and `entry_err_o`, `recov_viol_o` and `stale_o` are all 0.
- R2: With the default parameters, a high level applied to `sleep_req_i` before a clock edge clears `access_ok_o` after the third edge and sets `sleep_o` after the fifth edge. The count is 2 synchroniser edges, plus 1 decision edge, plus 2 entry cycles. `sleep_o` stays 0 through the fourth edge.
- R3: With the default parameters, a low level applied to `sleep_req_i` while asleep clears `sleep_o` after the third edge and sets `access_ok_o` after the fifth edge. `access_ok_o` stays 0 through the fourth edge.
- R4: `access_go_o` equals `sel_i & (strb_a_i | strb_b_i)` while `access_ok_o` is 1, and is 0 in every other phase.
- R5: If `sel_i`, `strb_a_i` or `strb_b_i` is high on the edge where entry starts, `entry_err_o` is set on that edge and stays 1 until reset.
- R6: If `busy_i` is high on the edge where entry starts, `stale_o` is 1 for exactly the following cycle.
- R7: Any of `sel_i`, `strb_a_i` or `strb_b_i` high on an edge inside the recovery phase sets `recov_viol_o`, which stays 1 until reset. The same inputs while asleep set no flag.
- R8: Once started, entry always completes. A request that is dropped during entry produces a full sleep phase followed by a full recovery phase.
- R9: A request that is raised again during recovery lets recovery finish. `access_ok_o` is then 1 for exactly one cycle before a new entry begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| sel_i | input | 1 | Combined chip enable, active high |
| strb_a_i | input | 1 | Processor-side address strobe, active high |
| strb_b_i | input | 1 | Controller-side address strobe, active high |
| busy_i | input | 1 | An access is in flight |
| sleep_o | output | 1 | Low-power phase active |
| access_ok_o | output | 1 | Fully awake, accesses allowed |
| access_go_o | output | 1 | Gated access start |
| entry_err_o | output | 1 | Sticky: device was selected when entry started |
| recov_viol_o | output | 1 | Sticky: select or strobe seen during recovery |
| stale_o | output | 1 | One-cycle pulse: in-flight access invalidated |

## Verification
On every cycle, the assertions check the following:
- no access is granted outside the awake phase;
- the sleep and awake flags are never high together;
- both error flags stay set until reset;
- the invalidation pulse lasts a single cycle;
- phases never skip entry or recovery.

The exact edge counts of entry and exit can only be shown by the bench's scenarios. The same holds for completion of entry after a dropped request, for re-entry after a request raised during recovery, and for which input conditions set each flag.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE  = 2'd0,
    PH_ENTER  = 2'd1,
    PH_ASLEEP = 2'd2,
    PH_EXIT   = 2'd3
  } phase_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= 1'b0;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  output phase_e phase_o,
  output logic   enter_o
);
  localparam int unsigned MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_AWAKE: if (req_i) begin
        phase_d = PH_ENTER;
        cnt_d   = CNT_W'(ENTER_CYC - 1);
      end
      PH_ENTER: begin
        if (cnt_q == '0) phase_d = PH_ASLEEP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_ASLEEP: if (!req_i) begin
        phase_d = PH_EXIT;
        cnt_d   = CNT_W'(EXIT_CYC - 1);
      end
      PH_EXIT: begin
        if (cnt_q == '0) phase_d = PH_AWAKE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  // entry decision taken on this edge
  assign enter_o = (phase_q == PH_AWAKE) && req_i;
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
  import sleep_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   enter_i,
  input  logic   sel_i,
  input  logic   strb_a_i,
  input  logic   strb_b_i,
  input  logic   busy_i,
  output logic   access_go_o,
  output logic   entry_err_o,
  output logic   recov_viol_o,
  output logic   stale_o
);
  logic any_act;
  logic entry_err_q, recov_viol_q, stale_q;

  assign any_act     = sel_i | strb_a_i | strb_b_i;
  assign access_go_o = (phase_i == PH_AWAKE) & sel_i & (strb_a_i | strb_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_err_q  <= 1'b0;
      recov_viol_q <= 1'b0;
      stale_q      <= 1'b0;
    end else begin
      if (enter_i && any_act)                  entry_err_q  <= 1'b1;
      if ((phase_i == PH_EXIT) && any_act)     recov_viol_q <= 1'b1;
      stale_q <= enter_i & busy_i;
    end
  end

  assign entry_err_o  = entry_err_q;
  assign recov_viol_o = recov_viol_q;
  assign stale_o      = stale_q;
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTER_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic sel_i,
  input  logic strb_a_i,
  input  logic strb_b_i,
  input  logic busy_i,
  output logic sleep_o,
  output logic access_ok_o,
  output logic access_go_o,
  output logic entry_err_o,
  output logic recov_viol_o,
  output logic stale_o
);
  logic   req_s;
  logic   enter;
  phase_e phase;

  sleep_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sleep_req_i),
    .q_o   (req_s)
  );

  sleep_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_s),
    .phase_o(phase),
    .enter_o(enter)
  );

  sleep_guard i_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .enter_i     (enter),
    .sel_i       (sel_i),
    .strb_a_i    (strb_a_i),
    .strb_b_i    (strb_b_i),
    .busy_i      (busy_i),
    .access_go_o (access_go_o),
    .entry_err_o (entry_err_o),
    .recov_viol_o(recov_viol_o),
    .stale_o     (stale_o)
  );

  assign sleep_o     = (phase == PH_ASLEEP);
  assign access_ok_o = (phase == PH_AWAKE);
endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_o,
  input logic access_ok_o,
  input logic access_go_o,
  input logic entry_err_o,
  input logic recov_viol_o,
  input logic stale_o
);
  assert_go_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_ok_o |-> !access_go_o);

  assert_phase_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sleep_o && access_ok_o));

  assert_no_skip_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(access_ok_o) |-> !sleep_o);

  assert_no_skip_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |=> (sleep_o || !access_ok_o));

  assert_entry_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_err_o |=> entry_err_o);

  assert_viol_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_viol_o |=> recov_viol_o);

  assert_stale_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_o |=> !stale_o);
endmodule

bind sleep_ctrl sleep_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_o     (sleep_o),
  .access_ok_o (access_ok_o),
  .access_go_o (access_go_o),
  .entry_err_o (entry_err_o),
  .recov_viol_o(recov_viol_o),
  .stale_o     (stale_o)
);

// File: tb/test_sleep_ctrl.sv
`timescale 1ns/1ps
module test_sleep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, sel = 1'b0, sa = 1'b0, sb = 1'b0, busy = 1'b0;
  logic sleep, ok, go, eerr, viol, stale;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sleep_ctrl i_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .sel_i(sel),
    .strb_a_i(sa), .strb_b_i(sb), .busy_i(busy),
    .sleep_o(sleep), .access_ok_o(ok), .access_go_o(go),
    .entry_err_o(eerr), .recov_viol_o(viol), .stale_o(stale)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = 0; sel = 0; sa = 0; sb = 0; busy = 0;
    edges(3);
    rst_n = 1'b1;
    edges(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sleep", sleep, 1'b0);
    chk("R1 ok", ok, 1'b1);
    chk("R1 eerr", eerr, 1'b0);
    chk("R1 viol", viol, 1'b0);
    chk("R1 stale", stale, 1'b0);
  endtask

  task automatic t_entry();
    req = 1'b1;
    edges(2); chk("R2 ok edge2", ok, 1'b1);
    edges(1); chk("R2 ok edge3", ok, 1'b0); chk("R2 sleep edge3", sleep, 1'b0);
    edges(1); chk("R2 sleep edge4", sleep, 1'b0);
    edges(1); chk("R2 sleep edge5", sleep, 1'b1);
    chk("R5 no entry err", eerr, 1'b0);
    chk("R6 no stale", stale, 1'b0);
  endtask

  task automatic t_asleep_block();
    sel = 1'b1; sa = 1'b1;
    #1 chk("R4 go blocked asleep", go, 1'b0);
    edges(1);
    chk("R7 no viol asleep", viol, 1'b0);
    sel = 1'b0; sa = 1'b0;
  endtask

  task automatic t_exit_viol();
    req = 1'b0;
    edges(2); chk("R3 sleep edge2", sleep, 1'b1);
    edges(1); chk("R3 sleep edge3", sleep, 1'b0); chk("R3 ok edge3", ok, 1'b0);
    sb = 1'b1; sel = 1'b1;
    #1 chk("R7 go blocked in recovery", go, 1'b0);
    edges(1); chk("R3 ok edge4", ok, 1'b0); chk("R7 viol set", viol, 1'b1);
    sb = 1'b0; sel = 1'b0;
    edges(1); chk("R3 ok edge5", ok, 1'b1);
    edges(3); chk("R7 viol sticky", viol, 1'b1);
  endtask

  task automatic t_go_awake();
    sel = 1'b1; sb = 1'b1;
    #1 chk("R4 go sel+strobe", go, 1'b1);
    sb = 1'b0;
    #1 chk("R4 go no strobe", go, 1'b0);
    sel = 1'b0; sa = 1'b1;
    #1 chk("R4 go no sel", go, 1'b0);
    sa = 1'b0;
  endtask

  task automatic t_entry_err();
    do_reset();
    req = 1'b1; sel = 1'b1; busy = 1'b1;
    edges(2); chk("R6 stale before", stale, 1'b0);
    edges(1); chk("R5 entry err", eerr, 1'b1); chk("R6 stale pulse", stale, 1'b1);
    sel = 1'b0; busy = 1'b0;
    edges(1); chk("R6 stale cleared", stale, 1'b0);
    edges(1); chk("R2 sleep with err", sleep, 1'b1);
    req = 1'b0;
    edges(6); chk("R5 err sticky", eerr, 1'b1); chk("R3 awake again", ok, 1'b1);
    do_reset();
    chk("R5 reset clears", eerr, 1'b0);
  endtask

  task automatic t_short_req();
    do_reset();
    req = 1'b1;
    edges(3);
    req = 1'b0;
    edges(1); chk("R8 still entering", sleep, 1'b0);
    edges(1); chk("R8 sleep reached", sleep, 1'b1);
    edges(1); chk("R8 exiting", sleep, 1'b0); chk("R8 ok low", ok, 1'b0);
    edges(1); chk("R8 ok still low", ok, 1'b0);
    edges(1); chk("R8 awake", ok, 1'b1);
  endtask

  task automatic t_reenter();
    do_reset();
    req = 1'b1; edges(6);
    chk("R9 asleep", sleep, 1'b1);
    req = 1'b0; edges(3);
    req = 1'b1;
    edges(1); chk("R9 ok low edge4", ok, 1'b0);
    edges(1); chk("R9 ok one cycle", ok, 1'b1);
    edges(1); chk("R9 reentering", ok, 1'b0);
    edges(2); chk("R9 asleep again", sleep, 1'b1);
    req = 1'b0; edges(6);
  endtask

  initial begin
    t_reset();
    t_go_awake();
    t_entry();
    t_asleep_block();
    t_exit_viol();
    do_reset();
    chk("R7 reset clears", viol, 1'b0);
    t_entry_err();
    t_short_req();
    t_reenter();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule